// File: doc/BRIEF.md
# Disk Data FIFO with Host Handshake

This block sits between a host data port and the byte stream of a disk data path. It holds up to 16 bytes, and it drives the handshake that the host polls on a status port. That handshake is a ready bit and a direction bit, not full and empty flags. A controller sequencer drives the block through three phases:
- a command phase, where parameter bytes pass one at a time;
- an execution phase, where sector data streams through the queue;
- a result phase, where status bytes pass back one at a time.

The queue is bypassed in the command and result phases, where it holds a single byte. It is emptied on every phase change made by the sequencer.

During execution, a request goes out either on the ready bit (polled mode) or on a DMA request pin. The request rises when the occupancy reaches a programmable threshold, and it stays up until the burst has drained or filled the queue. If the disk side finds the queue full (on a read) or empty (on a write), the error is latched and the transfer stops. On a write, the disk side then receives zero bytes for the rest of the sector. A terminal-count pulse also ends the transfer.

Top module: `dskq_top`

## Requirements
- R1: After reset the queue is disabled (single-byte depth in execution), the threshold is 0, DMA mode is selected, and the status byte reads 0x80.
- R2: In the command phase the queue holds one byte. Ready (bit 7) drops while the byte waits, a host write while it waits is discarded, and the byte appears on the disk read data.
- R3: Busy (bit 4) rises with the first host write in idle. It stays set through the execution and result phases, and it clears when the sequencer returns to idle.
- R4: Direction (bit 6) is 0 in idle and command, 1 in result, and equal to the transfer direction in execution (1 = disk to host).
- R5: Any phase change ordered by the sequencer empties the queue, so a byte left over from the command phase is never seen in execution.
- R6: With the queue enabled, execution holds 16 bytes in first-in first-out order. With it disabled, execution holds 1 byte.
- R7: On a disk-to-host transfer the request rises when the filled count reaches threshold+1, and it holds until the queue is empty.
- R8: On a host-to-disk transfer the request rises when the free count reaches threshold+1, and it holds until the queue is full.
- R9: Non-DMA (bit 5) is 1 only in execution in polled mode. In polled mode the request appears on ready; in DMA mode ready stays 0 in execution and the request appears on `dma_req`.
- R10: A disk push into a full queue during a read execution sets `xfer_err`, discards that byte, and drops the request.
- R11: A disk pop from an empty queue during a write execution sets `xfer_err` and drops the request. From then on the disk read data is 0x00 and host writes are refused.
- R12: `dma_tc` in execution sets `tc_hit` and drops the request. Both `tc_hit` and `xfer_err` clear on the next entry into execution.
- R13: In the result phase a byte pushed by the sequencer raises ready with direction 1. A host read returns that byte and drops ready.
- R14: `sts_data` shows the current status byte whenever `sts_rd` is high and 0 otherwise. It reflects a transfer in the cycle right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_load | input | 1 | Load the configuration fields below |
| cfg_fifo_on | input | 1 | 1 = queue enabled in execution |
| cfg_thr | input | 4 | Request threshold (request at thr+1) |
| cfg_polled | input | 1 | 1 = polled execution, 0 = DMA |
| seq_go_exec | input | 1 | Command to execution |
| seq_rd_dir | input | 1 | Transfer direction, sampled with seq_go_exec (1 = disk to host) |
| seq_go_result | input | 1 | Execution to result |
| seq_go_idle | input | 1 | Command or result to idle |
| hst_wr | input | 1 | Host data-port write strobe |
| hst_wdata | input | 8 | Host write data |
| hst_rd | input | 1 | Host data-port read strobe |
| hst_rdata | output | 8 | Host read data (0 when not reading) |
| sts_rd | input | 1 | Status-port read strobe |
| sts_data | output | 8 | Status byte: 7 ready, 6 direction, 5 non-DMA, 4 busy, 3:0 zero |
| dsk_push | input | 1 | Disk side writes a byte |
| dsk_wdata | input | 8 | Disk side write data |
| dsk_pop | input | 1 | Disk side takes a byte |
| dsk_rdata | output | 8 | Byte for the disk side (0x00 when none) |
| dsk_avail | output | 1 | A byte waits for the disk side |
| dsk_room | output | 1 | The disk side may push |
| dma_req | output | 1 | DMA service request |
| dma_tc | input | 1 | DMA terminal count |
| xfer_err | output | 1 | Overrun or underrun latched |
| tc_hit | output | 1 | Terminal count seen in this execution |

## Verification
The hardest states to reach are the hold windows of a burst. On a read, the occupancy has fallen below the threshold while the request must stay up. On a write, the queue has filled, and the request must stay down until the free count again reaches the threshold. The stimulus reaches them with full-depth bursts: the queue is filled or drained to within a few bytes of the threshold, and ready is checked on each side of it. The error paths are reached by strobing the disk side against the handshake, with a push into a full single-byte queue and a pop from an empty one. The zero padding and the refused host writes are then checked at the disk port.

// File: rtl/dskq_pkg.sv
package dskq_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_EXEC, PH_RES} dskq_phase_e;

  // usable depth: full depth only when executing with the queue enabled
  function automatic int cap_of(input bit in_exec, input bit fifo_on, input int depth);
    return (in_exec && fifo_on) ? depth : 1;
  endfunction

  // request level: threshold+1, clamped to the usable depth
  function automatic bit level_met(input int lvl, input int thr, input int cap);
    int need;
    need = thr + 1;
    if (need > cap) need = cap;
    return lvl >= need;
  endfunction

  function automatic logic [7:0] pack_status(input logic rqm, input logic dio,
                                             input logic ndma, input logic busy);
    return {rqm, dio, ndma, busy, 4'b0000};
  endfunction
endpackage

// File: rtl/dskq_cfg.sv
module dskq_cfg #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          fifo_on_in,
  input  logic [TW-1:0] thr_in,
  input  logic          polled_in,
  output logic          fifo_on,
  output logic [TW-1:0] thr,
  output logic          polled
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_on <= 1'b0;
      thr     <= '0;
      polled  <= 1'b0;
    end else if (load) begin
      fifo_on <= fifo_on_in;
      thr     <= thr_in;
      polled  <= polled_in;
    end
  end

  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(fifo_on) && $stable(thr) && $stable(polled));
endmodule

// File: rtl/dskq_ring.sv
module dskq_ring #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            push,
  input  logic [W-1:0]    wdata,
  input  logic            pop,
  output logic [W-1:0]    rdata,
  output logic [CNTW-1:0] count
);
  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] wptr, rptr;

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rptr];

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);
  p_no_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
  p_no_push_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> int'(count) < DEPTH);
endmodule

// File: rtl/dskq_phase.sv
module dskq_phase
  import dskq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hst_first,
  input  logic        go_exec,
  input  logic        rd_dir,
  input  logic        go_result,
  input  logic        go_idle,
  input  logic        dma_tc,
  input  logic        under_ev,
  input  logic        over_ev,
  output dskq_phase_e phase,
  output logic        dir_rd,
  output logic        flush,
  output logic        err,
  output logic        tc_hit
);
  always_comb begin
    flush = ((phase == PH_CMD)  && (go_exec || go_idle)) ||
            ((phase == PH_EXEC) && go_result) ||
            ((phase == PH_RES)  && go_idle);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      dir_rd <= 1'b0;
      err    <= 1'b0;
      tc_hit <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (hst_first) phase <= PH_CMD;
        PH_CMD: begin
          if (go_exec) begin
            phase  <= PH_EXEC;
            dir_rd <= rd_dir;
            err    <= 1'b0;
            tc_hit <= 1'b0;
          end else if (go_idle) begin
            phase <= PH_IDLE;
          end
        end
        PH_EXEC: begin
          if (under_ev || over_ev) err <= 1'b1;
          if (dma_tc) tc_hit <= 1'b1;
          if (go_result) phase <= PH_RES;
        end
        PH_RES: if (go_idle) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && $past(phase) == PH_EXEC && $past(err)) |-> err);
  p_entry_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && $past(phase) == PH_CMD) |-> (!err && !tc_hit));
endmodule

// File: rtl/dskq_svc.sv
module dskq_svc
  import dskq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TW    = 4,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  dskq_phase_e     phase,
  input  logic            dir_rd,
  input  logic            polled,
  input  logic            fifo_on,
  input  logic [TW-1:0]   thr,
  input  logic [CNTW-1:0] count,
  input  logic            err,
  input  logic            tc_hit,
  output logic            rqm,
  output logic            dio,
  output logic            ndma,
  output logic            dma_req,
  output logic            svc
);
  logic burst_q, in_exec, met, done;
  int   cap_i, lvl, thr_i;

  always_comb begin
    in_exec = (phase == PH_EXEC);
    cap_i   = cap_of(in_exec, fifo_on, DEPTH);
    thr_i   = fifo_on ? int'(thr) : 0;
    lvl     = dir_rd ? int'(count) : cap_i - int'(count);
    done    = dir_rd ? (count == '0) : (int'(count) >= cap_i);
    met     = level_met(lvl, thr_i, cap_i);
    svc     = in_exec && !err && !tc_hit && (met || (burst_q && !done));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burst_q <= 1'b0;
    else        burst_q <= svc;
  end

  always_comb begin
    ndma    = in_exec && polled;
    dma_req = in_exec && !polled && svc;
    unique case (phase)
      PH_IDLE, PH_CMD: begin rqm = (count == '0); dio = 1'b0; end
      PH_RES:          begin rqm = (count != '0); dio = 1'b1; end
      default:         begin rqm = polled && svc;  dio = dir_rd; end
    endcase
  end

  p_req_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_req && rqm));
  p_ndma_exec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ndma |-> phase == PH_EXEC);
endmodule

// File: rtl/dskq_top.sv
module dskq_top
  import dskq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int TW    = 4,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          cfg_fifo_on,
  input  logic [TW-1:0] cfg_thr,
  input  logic          cfg_polled,
  input  logic          seq_go_exec,
  input  logic          seq_rd_dir,
  input  logic          seq_go_result,
  input  logic          seq_go_idle,
  input  logic          hst_wr,
  input  logic [W-1:0]  hst_wdata,
  input  logic          hst_rd,
  output logic [W-1:0]  hst_rdata,
  input  logic          sts_rd,
  output logic [7:0]    sts_data,
  input  logic          dsk_push,
  input  logic [W-1:0]  dsk_wdata,
  input  logic          dsk_pop,
  output logic [W-1:0]  dsk_rdata,
  output logic          dsk_avail,
  output logic          dsk_room,
  output logic          dma_req,
  input  logic          dma_tc,
  output logic          xfer_err,
  output logic          tc_hit
);
  logic            fifo_on, polled;
  logic [TW-1:0]   thr;
  dskq_phase_e     phase;
  logic            dir_rd, flush, err;
  logic [CNTW-1:0] count;
  logic [W-1:0]    head;
  logic            rqm, dio, ndma, svc;
  // named internal events
  logic            h2d, in_exec, can_push, push_ok, pop_ok, under_ev, over_ev, hst_first;
  logic            prod_stb, cons_stb;
  logic [W-1:0]    prod_data;
  logic [7:0]      status;
  int              cap_i;

  dskq_cfg #(.TW(TW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .fifo_on_in(cfg_fifo_on),
    .thr_in(cfg_thr), .polled_in(cfg_polled),
    .fifo_on(fifo_on), .thr(thr), .polled(polled));

  always_comb begin
    in_exec   = (phase == PH_EXEC);
    h2d       = (phase == PH_IDLE) || (phase == PH_CMD) || (in_exec && !dir_rd);
    cap_i     = cap_of(in_exec, fifo_on, DEPTH);
    can_push  = (int'(count) < cap_i) && !(in_exec && err);
    prod_stb  = h2d ? hst_wr : dsk_push;
    prod_data = h2d ? hst_wdata : dsk_wdata;
    cons_stb  = h2d ? dsk_pop : hst_rd;
    push_ok   = prod_stb && can_push && !flush;
    pop_ok    = cons_stb && (count != '0) && !flush;
    over_ev   = in_exec && dir_rd && dsk_push && (int'(count) >= cap_i);
    under_ev  = in_exec && !dir_rd && dsk_pop && (count == '0);
    hst_first = (phase == PH_IDLE) && push_ok;
  end

  dskq_phase u_phase (
    .clk(clk), .rst_n(rst_n), .hst_first(hst_first), .go_exec(seq_go_exec),
    .rd_dir(seq_rd_dir), .go_result(seq_go_result), .go_idle(seq_go_idle),
    .dma_tc(dma_tc), .under_ev(under_ev), .over_ev(over_ev),
    .phase(phase), .dir_rd(dir_rd), .flush(flush), .err(err), .tc_hit(tc_hit));

  dskq_ring #(.DEPTH(DEPTH), .W(W)) u_ring (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push_ok), .wdata(prod_data),
    .pop(pop_ok), .rdata(head), .count(count));

  dskq_svc #(.DEPTH(DEPTH), .TW(TW)) u_svc (
    .clk(clk), .rst_n(rst_n), .phase(phase), .dir_rd(dir_rd), .polled(polled),
    .fifo_on(fifo_on), .thr(thr), .count(count), .err(err), .tc_hit(tc_hit),
    .rqm(rqm), .dio(dio), .ndma(ndma), .dma_req(dma_req), .svc(svc));

  always_comb begin
    status    = pack_status(rqm, dio, ndma, phase != PH_IDLE);
    sts_data  = sts_rd ? status : 8'h00;
    dsk_avail = h2d && (count != '0);
    dsk_rdata = dsk_avail ? head : '0;
    hst_rdata = (hst_rd && !h2d && (count != '0)) ? head : '0;
    dsk_room  = !h2d && can_push;
    xfer_err  = err;
  end

  p_flush_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && $past(phase) == PH_CMD) |-> count == '0);
  p_pad_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dsk_pop && err && in_exec && !dir_rd) |-> dsk_rdata == '0);
  p_busy_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !status[4]);
  p_cmd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CMD) |-> count <= CNTW'(1));
  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && err) |-> !svc);
endmodule

// File: tb/sim_dskq_top.sv
`timescale 1ns/1ps
module sim_dskq_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 0, cfg_fifo_on = 0, cfg_polled = 0;
  logic [3:0] cfg_thr = 0;
  logic seq_go_exec = 0, seq_rd_dir = 0, seq_go_result = 0, seq_go_idle = 0;
  logic hst_wr = 0, hst_rd = 0, sts_rd = 1, dsk_push = 0, dsk_pop = 0, dma_tc = 0;
  logic [7:0] hst_wdata = 0, dsk_wdata = 0;
  logic [7:0] hst_rdata, sts_data, dsk_rdata;
  logic dsk_avail, dsk_room, dma_req, xfer_err, tc_hit;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dskq_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_fifo_on(cfg_fifo_on),
    .cfg_thr(cfg_thr), .cfg_polled(cfg_polled), .seq_go_exec(seq_go_exec),
    .seq_rd_dir(seq_rd_dir), .seq_go_result(seq_go_result), .seq_go_idle(seq_go_idle),
    .hst_wr(hst_wr), .hst_wdata(hst_wdata), .hst_rd(hst_rd), .hst_rdata(hst_rdata),
    .sts_rd(sts_rd), .sts_data(sts_data), .dsk_push(dsk_push), .dsk_wdata(dsk_wdata),
    .dsk_pop(dsk_pop), .dsk_rdata(dsk_rdata), .dsk_avail(dsk_avail), .dsk_room(dsk_room),
    .dma_req(dma_req), .dma_tc(dma_tc), .xfer_err(xfer_err), .tc_hit(tc_hit));

  // {thr[3:0], bytes pushed[4:0], expected ready} for disk-to-host polled bursts
  localparam logic [9:0] VEC [8] = '{
    {4'd0,  5'd0,  1'b0}, {4'd0,  5'd1,  1'b1}, {4'd3,  5'd3,  1'b0}, {4'd3,  5'd4,  1'b1},
    {4'd7,  5'd7,  1'b0}, {4'd7,  5'd8,  1'b1}, {4'd15, 5'd15, 1'b0}, {4'd15, 5'd16, 1'b1}};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cfg_load = 0; seq_go_exec = 0; seq_go_result = 0; seq_go_idle = 0;
    hst_wr = 0; hst_rd = 0; dsk_push = 0; dsk_pop = 0; dma_tc = 0;
  endtask

  task automatic configure(input logic fon, input logic [3:0] t, input logic pol);
    cfg_load = 1; cfg_fifo_on = fon; cfg_thr = t; cfg_polled = pol; tick();
  endtask

  task automatic cmd_byte(input logic [7:0] b);
    hst_wr = 1; hst_wdata = b; tick();
    dsk_pop = 1; tick();
  endtask

  task automatic enter_exec(input logic rd);
    seq_go_exec = 1; seq_rd_dir = rd; tick();
  endtask

  task automatic finish_cmd();
    seq_go_result = 1; tick();
    seq_go_idle = 1; tick();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 / R14 reset state and gating of the status port
    check("R1 reset status", sts_data, 8'h80);
    check("R1 reset dma_req/err", {6'b0, dma_req, xfer_err}, 8'h00);
    sts_rd = 0; #1;
    check("R14 status gated off", sts_data, 8'h00);
    sts_rd = 1;

    // R1 single-byte depth by default, R9 DMA request, R10 overrun
    cmd_byte(8'hA1);
    enter_exec(1'b1);
    check("R9 DMA mode read idle req", {7'b0, dma_req}, 8'h00);
    check("R4 exec read dir, DMA", sts_data, 8'h50);
    dsk_push = 1; dsk_wdata = 8'h21; tick();
    check("R1 default depth 1 (room)", {7'b0, dsk_room}, 8'h00);
    check("R9 dma_req raised", {7'b0, dma_req}, 8'h01);
    dsk_push = 1; dsk_wdata = 8'h22; tick();
    check("R10 overrun flag", {7'b0, xfer_err}, 8'h01);
    check("R10 request dropped", {7'b0, dma_req}, 8'h00);
    hst_rd = 1; #1;
    check("R10 overrun byte discarded", hst_rdata, 8'h21);
    tick();
    finish_cmd();

    // R2 / R3 command byte path
    hst_wr = 1; hst_wdata = 8'h5A; tick();
    check("R3 busy on first byte, R2 ready low", sts_data, 8'h10);
    check("R2 byte to disk side", dsk_rdata, 8'h5A);
    hst_wr = 1; hst_wdata = 8'h33; tick();
    dsk_pop = 1; #1;
    check("R2 second write discarded", dsk_rdata, 8'h5A);
    tick();
    check("R2 ready after pop", sts_data, 8'h90);
    check("R2 nothing left", {7'b0, dsk_avail}, 8'h00);
    seq_go_idle = 1; tick();
    check("R3 busy clears at idle", sts_data, 8'h80);

    // R5 flush, R11 underrun, R13 result phase
    hst_wr = 1; hst_wdata = 8'h11; tick();
    enter_exec(1'b0);
    check("R5 leftover flushed", {7'b0, dsk_avail}, 8'h00);
    check("R4 exec write dir, busy", sts_data, 8'h10);
    check("R9 DMA write req", {7'b0, dma_req}, 8'h01);
    dsk_pop = 1; #1;
    check("R11 empty pop data", dsk_rdata, 8'h00);
    tick();
    check("R11 underrun flag", {7'b0, xfer_err}, 8'h01);
    check("R11 request dropped", {7'b0, dma_req}, 8'h00);
    hst_wr = 1; hst_wdata = 8'h77; tick();
    check("R11 host write refused", {7'b0, dsk_avail}, 8'h00);
    check("R11 zero padding", dsk_rdata, 8'h00);
    seq_go_result = 1; tick();
    dsk_push = 1; dsk_wdata = 8'hC3; tick();
    check("R13 result ready dir=1", sts_data, 8'hD0);
    hst_rd = 1; #1;
    check("R13 result byte", hst_rdata, 8'hC3);
    tick();
    check("R13 ready drops, R14 no delay", sts_data, 8'h50);
    seq_go_idle = 1; tick();
    check("R3 idle after result", sts_data, 8'h80);

    // R7 read threshold table
    for (int i = 0; i < 8; i++) begin
      configure(1'b1, VEC[i][9:6], 1'b1);
      cmd_byte(8'h0F);
      enter_exec(1'b1);
      for (int k = 0; k < int'(VEC[i][5:1]); k++) begin
        dsk_push = 1; dsk_wdata = 8'(k); tick();
      end
      check($sformatf("R7 thr=%0d n=%0d ready", VEC[i][9:6], VEC[i][5:1]),
            {7'b0, sts_data[7]}, {7'b0, VEC[i][0]});
      finish_cmd();
    end

    // R6 full depth and order, R7 hold until empty, R9 polled
    configure(1'b1, 4'd3, 1'b1);
    cmd_byte(8'h0E);
    enter_exec(1'b1);
    for (int k = 0; k < 16; k++) begin
      dsk_push = 1; dsk_wdata = 8'(8'h80 + k); tick();
    end
    check("R6 sixteen held, no room", {6'b0, dsk_room, xfer_err}, 8'h00);
    check("R9 polled read status", sts_data, 8'hF0);
    for (int k = 0; k < 14; k++) begin
      hst_rd = 1; #1;
      check("R6 fifo order", hst_rdata, 8'(8'h80 + k));
      tick();
    end
    check("R7 burst holds below threshold", sts_data, 8'hF0);
    hst_rd = 1; tick();
    hst_rd = 1; tick();
    check("R7 ready drops when empty", sts_data, 8'h70);
    finish_cmd();

    // R8 write threshold with hold until full
    cmd_byte(8'h0D);
    enter_exec(1'b0);
    check("R8 write request at entry", sts_data, 8'hB0);
    for (int k = 0; k < 13; k++) begin
      hst_wr = 1; hst_wdata = 8'(8'h40 + k); tick();
    end
    check("R8 burst holds, free 3", sts_data, 8'hB0);
    for (int k = 13; k < 16; k++) begin
      hst_wr = 1; hst_wdata = 8'(8'h40 + k); tick();
    end
    check("R8 full drops ready", sts_data, 8'h30);
    for (int k = 0; k < 3; k++) begin
      dsk_pop = 1; #1;
      check("R8 disk order", dsk_rdata, 8'(8'h40 + k));
      tick();
    end
    check("R8 free 3 below threshold", sts_data, 8'h30);
    dsk_pop = 1; tick();
    check("R8 free 4 raises ready", sts_data, 8'hB0);
    finish_cmd();

    // R12 terminal count
    configure(1'b1, 4'd0, 1'b0);
    cmd_byte(8'h0C);
    enter_exec(1'b0);
    check("R12 request before tc", {7'b0, dma_req}, 8'h01);
    dma_tc = 1; tick();
    check("R12 tc_hit and request", {6'b0, tc_hit, dma_req}, 8'h02);
    finish_cmd();
    cmd_byte(8'h0B);
    enter_exec(1'b0);
    check("R12 tc_hit clears on entry", {6'b0, tc_hit, dma_req}, 8'h01);
    finish_cmd();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule